// File: doc/BRIEF.md
# Sequential Floating-Point Adder with Single-Step Shifters

This block adds two 32-bit floating-point words. Each word holds a sign bit (bit 31), an 8-bit exponent (bits 30:23) stored with an offset of 128, and a 23-bit fraction (bits 22:0) that sits below an implicit leading one. A word whose exponent field is zero stands for zero, whatever its fraction bits are. The block has no subtract control. To subtract, the caller inverts bit 31 of one operand before presenting it.

Each operation passes through three internal stages. The alignment stage moves the smaller operand's significand right by the full exponent gap in one combinational step. The add stage either sums the two significands or takes the difference between them. The normalization stage shifts the raw sum in one step, by an amount taken from a leading-zero counter. Because of this, every operation takes the same fixed number of clocks, whatever the data. Results that fall off the top of the exponent range saturate. Results that fall off the bottom become zero.

Transfers use a four-phase request/done handshake. The caller raises `req` with both operands valid. The block later raises `done`, holds the result steady while `req` stays high, and drops `done` once `req` falls.

Top module: `fpadd_seq`

## Requirements
- R1: Two operands of the same sign produce the truncated sum of their magnitudes, with that common sign (for example 0x40000000 + 0x40000000 = 0x40800000).
- R2: Operands of opposite sign produce the larger magnitude minus the smaller one, with the sign of the larger. Subtraction is done by the caller inverting bit 31 of one operand.
- R3: Two operands that cancel exactly produce 0x00000000.
- R4: The smaller significand (implicit one included) moves right by the exponent difference, and bits shifted out of the 24-bit window are dropped before the add. When the difference is 24 or more, the larger operand comes back unchanged.
- R5: A carry out of the 24-bit significand sum shifts the sum right by one, drops the lowest bit and raises the exponent by one.
- R6: A difference with any number of leading zeros is renormalized in one step, and the exponent is reduced by the same count.
- R7: A result exponent above 255 gives the input sign with exponent and fraction all ones (0x7FFFFFFF or 0xFFFFFFFF).
- R8: A result exponent below 1 gives 0x00000000. No nonzero result ever carries a zero exponent field.
- R9: An operand whose exponent field is zero counts as zero, so the other operand is returned unchanged.
- R10: `done` rises on the fourth rising clock edge, counting the edge that samples `req` high in idle as the first.
- R11: While `req` stays high, `done` stays high and `sum_out` stays unchanged. `done` falls on the first edge that samples `req` low.
- R12: The operands are captured on the edge that accepts `req`. Later changes to `op_a` or `op_b` do not affect the result.
- R13: After reset, `done` is low and `sum_out` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request; held high until done is seen, then dropped |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| done | output | 1 | Result valid; held until req falls |
| sum_out | output | 32 | Result word |

## Verification
The hardest case to reach from the ports is a deep left renormalization. It needs two operands whose exponents differ by at most one and whose significands agree in nearly every bit. Random words almost never produce that. Directed tasks build these pairs on purpose:
- a one-bit gap in which the bit dropped during alignment leaves a difference of a single LSB, which forces a 23-place shift;
- an equal-exponent pair at the bottom of the range, which drives the exponent below one.

A sweep with close exponents then covers the shallower shift amounts, checked against a model written from the requirements.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

   // Sequencer states of the adder
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ALIGN = 3'd1,
      ST_ADD   = 3'd2,
      ST_NORM  = 3'd3,
      ST_DONE  = 3'd4
   } fpadd_state_e;

   // Direction selector for the shared barrel shifter
   localparam bit SHIFT_RIGHT = 1'b0;
   localparam bit SHIFT_LEFT  = 1'b1;

endpackage

// File: rtl/fpadd_shift.sv
module fpadd_shift #(
   parameter int W     = 24,
   parameter int AMT_W = 5,
   parameter bit LEFT  = 1'b0
) (
   input  logic [W-1:0]     din,
   input  logic [AMT_W-1:0] amt,
   output logic [W-1:0]     dout
);
   // One mux rank per amount bit; rank i moves by 2**i positions.
   logic [W-1:0] stage [AMT_W+1];

   assign stage[0] = din;

   for (genvar i = 0; i < AMT_W; i++) begin : g_rank
      if (LEFT) begin : g_left
         assign stage[i+1] = amt[i] ? (stage[i] << (1 << i)) : stage[i];
      end else begin : g_right
         assign stage[i+1] = amt[i] ? (stage[i] >> (1 << i)) : stage[i];
      end
   end

   assign dout = stage[AMT_W];

endmodule

// File: rtl/fpadd_lzc.sv
module fpadd_lzc #(
   parameter int W     = 25,
   parameter int CNT_W = 5
) (
   input  logic [W-1:0]     vec,
   output logic [CNT_W-1:0] cnt
);
   // Leading-zero count; an all-zero vector returns W.
   always_comb begin
      cnt = CNT_W'(W);
      for (int i = 0; i < W; i++) begin
         if (vec[i]) cnt = CNT_W'(W - 1 - i);
      end
   end

endmodule

// File: rtl/fpadd_align.sv
module fpadd_align
   import fpadd_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] op_x,
   input  logic [EXP_W+FRAC_W:0] op_y,
   output logic                  lg_sign,
   output logic [EXP_W-1:0]      lg_exp,
   output logic [FRAC_W:0]       lg_man,
   output logic [FRAC_W:0]       sm_man_al,
   output logic                  unlike
);
   localparam int W     = 1 + EXP_W + FRAC_W;
   localparam int MAN_W = FRAC_W + 1;
   localparam int SH_W  = $clog2(MAN_W);

   logic [W-1:0]     lg_word, sm_word;
   logic [EXP_W-1:0] sm_exp, gap;
   logic [MAN_W-1:0] sm_man, sm_shifted;
   logic             far;

   // Magnitude compare: exponent then fraction, as one unsigned field
   always_comb begin
      if (op_x[W-2:0] >= op_y[W-2:0]) begin
         lg_word = op_x;
         sm_word = op_y;
      end else begin
         lg_word = op_y;
         sm_word = op_x;
      end
   end

   assign lg_sign = lg_word[W-1];
   assign lg_exp  = lg_word[W-2:FRAC_W];
   assign sm_exp  = sm_word[W-2:FRAC_W];
   assign unlike  = op_x[W-1] ^ op_y[W-1];

   // A zero exponent field means zero: no implicit one
   assign lg_man = (lg_exp == '0) ? '0 : {1'b1, lg_word[FRAC_W-1:0]};
   assign sm_man = (sm_exp == '0) ? '0 : {1'b1, sm_word[FRAC_W-1:0]};

   assign gap = lg_exp - sm_exp;
   assign far = ({{(32-EXP_W){1'b0}}, gap} >= 32'(MAN_W));

   fpadd_shift #(
      .W     (MAN_W),
      .AMT_W (SH_W),
      .LEFT  (SHIFT_RIGHT)
   ) u_rsh (
      .din  (sm_man),
      .amt  (gap[SH_W-1:0]),
      .dout (sm_shifted)
   );

   assign sm_man_al = far ? '0 : sm_shifted;

endmodule

// File: rtl/fpadd_norm.sv
module fpadd_norm
   import fpadd_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [FRAC_W+1:0]     raw_sum,
   input  logic [EXP_W-1:0]      lg_exp,
   input  logic                  lg_sign,
   output logic [EXP_W+FRAC_W:0] word
);
   localparam int W       = 1 + EXP_W + FRAC_W;
   localparam int MAN_W   = FRAC_W + 1;
   localparam int SUM_W   = MAN_W + 1;
   localparam int LZ_W    = $clog2(SUM_W + 1);
   localparam int XE_W    = ((EXP_W > LZ_W) ? EXP_W : LZ_W) + 2;
   localparam int MAX_EXP = (1 << EXP_W) - 1;
   localparam logic signed [XE_W-1:0] MAX_X = XE_W'(MAX_EXP);
   localparam logic signed [XE_W-1:0] ONE_X = XE_W'(1);

   logic [LZ_W-1:0]         lz, shl;
   logic [FRAC_W-1:0]       frac_sh, frac_n;
   logic signed [XE_W-1:0]  xe, xe_n;

   fpadd_lzc #(
      .W     (SUM_W),
      .CNT_W (LZ_W)
   ) u_lzc (
      .vec (raw_sum),
      .cnt (lz)
   );

   assign shl = (lz == '0) ? '0 : (lz - LZ_W'(1));

   // Only the fraction bits are kept; the implicit one leaves the top.
   fpadd_shift #(
      .W     (FRAC_W),
      .AMT_W (LZ_W),
      .LEFT  (SHIFT_LEFT)
   ) u_lsh (
      .din  (raw_sum[FRAC_W-1:0]),
      .amt  (shl),
      .dout (frac_sh)
   );

   always_comb begin
      xe = XE_W'({1'b0, lg_exp});
      if (lz == '0) begin
         frac_n = raw_sum[SUM_W-2:1];
         xe_n   = xe + ONE_X;
      end else begin
         frac_n = frac_sh;
         xe_n   = xe - XE_W'(shl);
      end

      if (raw_sum == '0) begin
         word = '0;
      end else if (xe_n > MAX_X) begin
         word = {lg_sign, {(W-1){1'b1}}};
      end else if (xe_n < ONE_X) begin
         word = '0;
      end else begin
         word = {lg_sign, xe_n[EXP_W-1:0], frac_n};
      end
   end

endmodule

// File: rtl/fpadd_seq.sv
module fpadd_seq
   import fpadd_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req,
   input  logic [EXP_W+FRAC_W:0] op_a,
   input  logic [EXP_W+FRAC_W:0] op_b,
   output logic                  done,
   output logic [EXP_W+FRAC_W:0] sum_out
);
   localparam int W     = 1 + EXP_W + FRAC_W;
   localparam int MAN_W = FRAC_W + 1;
   localparam int SUM_W = MAN_W + 1;

   // Elaboration-time parameter checks
   if (EXP_W < 2 || EXP_W > 16) begin : g_bad_exp
      $error("fpadd_seq: EXP_W must lie in 2..16");
   end
   if (FRAC_W < 2) begin : g_bad_frac
      $error("fpadd_seq: FRAC_W must be at least 2");
   end
   if ($clog2(MAN_W) > EXP_W) begin : g_bad_ratio
      $error("fpadd_seq: exponent too narrow for significand shift");
   end

   fpadd_state_e     state;
   logic [W-1:0]     opa_q, opb_q;
   logic             lg_sign_c, unlike_c;
   logic [EXP_W-1:0] lg_exp_c;
   logic [MAN_W-1:0] lg_man_c, sm_man_c;
   logic             lg_sign_q, unlike_q;
   logic [EXP_W-1:0] lg_exp_q;
   logic [MAN_W-1:0] lg_man_q, sm_man_q;
   logic [SUM_W-1:0] sum_q;
   logic [W-1:0]     norm_c, res_q;
   logic             done_q;

   fpadd_align #(
      .EXP_W  (EXP_W),
      .FRAC_W (FRAC_W)
   ) u_align (
      .op_x      (opa_q),
      .op_y      (opb_q),
      .lg_sign   (lg_sign_c),
      .lg_exp    (lg_exp_c),
      .lg_man    (lg_man_c),
      .sm_man_al (sm_man_c),
      .unlike    (unlike_c)
   );

   fpadd_norm #(
      .EXP_W  (EXP_W),
      .FRAC_W (FRAC_W)
   ) u_norm (
      .raw_sum (sum_q),
      .lg_exp  (lg_exp_q),
      .lg_sign (lg_sign_q),
      .word    (norm_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         opa_q     <= '0;
         opb_q     <= '0;
         lg_sign_q <= 1'b0;
         lg_exp_q  <= '0;
         lg_man_q  <= '0;
         sm_man_q  <= '0;
         unlike_q  <= 1'b0;
         sum_q     <= '0;
         res_q     <= '0;
         done_q    <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (req) begin
                  opa_q <= op_a;
                  opb_q <= op_b;
                  state <= ST_ALIGN;
               end
            end
            ST_ALIGN: begin
               lg_sign_q <= lg_sign_c;
               lg_exp_q  <= lg_exp_c;
               lg_man_q  <= lg_man_c;
               sm_man_q  <= sm_man_c;
               unlike_q  <= unlike_c;
               state     <= ST_ADD;
            end
            ST_ADD: begin
               if (unlike_q) sum_q <= {1'b0, lg_man_q} - {1'b0, sm_man_q};
               else          sum_q <= {1'b0, lg_man_q} + {1'b0, sm_man_q};
               state <= ST_NORM;
            end
            ST_NORM: begin
               res_q  <= norm_c;
               done_q <= 1'b1;
               state  <= ST_DONE;
            end
            ST_DONE: begin
               if (!req) begin
                  done_q <= 1'b0;
                  state  <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign done    = done_q;
   assign sum_out = res_q;

   // Edge counter since acceptance, used only by the latency check
   logic [2:0] lat_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       lat_cnt <= '0;
      else if (state == ST_IDLE && req)                 lat_cnt <= 3'd1;
      else if (state != ST_IDLE && state != ST_DONE)    lat_cnt <= lat_cnt + 3'd1;
   end

   AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (lat_cnt == 3'd4)) else $error("done latency");          // R10
   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (done && req) |=> done) else $error("done dropped early");               // R11
   AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !req) |=> !done) else $error("done not released");              // R11
   AST_RESULT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (done && req) |=> $stable(sum_out)) else $error("result moved");         // R11
   AST_NO_DIRTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (sum_out[W-2:FRAC_W] != '0 || sum_out == '0)) else $error("zero exponent with nonzero bits"); // R8
   AST_NO_EARLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && req && !done) |=> !done) else $error("done too soon"); // R10

endmodule

// File: tb/fpadd_seq_tb.sv
module fpadd_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;
   logic        done;
   logic [31:0] sum_out;

   int n_checks = 0;
   int n_err    = 0;

   always #5 clk = ~clk;

   fpadd_seq u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req),
      .op_a    (op_a),
      .op_b    (op_b),
      .done    (done),
      .sum_out (sum_out)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] expv);
      n_checks++;
      if (got !== expv) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", tag, got, expv);
      end
   endtask

   // Model written from the requirements
   function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b);
      logic [31:0] l, s;
      int el, es, d, e;
      longint ml, ms, v;
      if (a[30:0] >= b[30:0]) begin l = a; s = b; end
      else begin l = b; s = a; end
      el = int'(l[30:23]);
      es = int'(s[30:23]);
      ml = (el == 0) ? 0 : (longint'(l[22:0]) + 64'h800000);
      ms = (es == 0) ? 0 : (longint'(s[22:0]) + 64'h800000);
      d = el - es;
      if (d >= 24) ms = 0; else ms = ms >>> d;
      v = (l[31] != s[31]) ? (ml - ms) : (ml + ms);
      if (v == 0) return 32'h0;
      e = el;
      if (v >= 64'h1000000) begin v = v >>> 1; e++; end
      while (v < 64'h800000) begin v = v <<< 1; e--; end
      if (e > 255) return {l[31], 31'h7FFFFFFF};
      if (e < 1) return 32'h0;
      return {l[31], 8'(e), v[22:0]};
   endfunction

   // Full handshake; returns the result and the edge count to done
   task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] res, output int lat);
      @(negedge clk);
      op_a = a;
      op_b = b;
      req  = 1'b1;
      lat  = 0;
      while (!done && lat < 20) begin
         @(posedge clk);
         lat++;
         @(negedge clk);
      end
      res = sum_out;
      req = 1'b0;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R13 done after reset", {31'b0, done}, 32'h0);
      check("R13 result after reset", sum_out, 32'h0);
   endtask

   task automatic t_like_signs();
      logic [31:0] r; int lat;
      run_op(32'h40000000, 32'h40000000, r, lat);
      check("R1 1+1", r, 32'h40800000);
      run_op(32'hC0000000, 32'hC0C00000, r, lat);
      check("R1 -1 + -3", r, 32'hC1000000);
   endtask

   task automatic t_unlike_signs();
      logic [31:0] r; int lat;
      run_op(32'h40C00000, 32'hC0000000, r, lat);
      check("R2 3-1", r, 32'h40800000);
      run_op(32'h40000000, 32'hC0C00000, r, lat);
      check("R2 1-3 sign of larger", r, 32'hC0800000);
      run_op(32'h40000000, 32'hC0000000, r, lat);
      check("R3 exact cancel", r, 32'h00000000);
      run_op(32'hC0C00000, 32'h40C00000, r, lat);
      check("R3 cancel negative first", r, 32'h00000000);
   endtask

   task automatic t_align();
      logic [31:0] r; int lat;
      run_op(32'h40000000, 32'h34800000, r, lat);
      check("R4 gap 23", r, 32'h40000001);
      run_op(32'h34800000, 32'h40000000, r, lat);
      check("R4 gap 23 swapped", r, 32'h40000001);
      run_op(32'h40000000, 32'h34000000, r, lat);
      check("R4 gap 24 unchanged", r, 32'h40000000);
      run_op(32'hC0123456, 32'h01000000, r, lat);
      check("R4 huge gap unchanged", r, 32'hC0123456);
   endtask

   task automatic t_carry();
      logic [31:0] r; int lat;
      // 1.5 + 1.5 = 3.0 ; (1+2^-23) + 1 = 2 after truncation of the LSB
      run_op(32'h40400000, 32'h40400000, r, lat);
      check("R5 carry 1.5+1.5", r, 32'h40C00000);
      run_op(32'h40000001, 32'h40000000, r, lat);
      check("R5 carry drops LSB", r, 32'h40800000);
   endtask

   task automatic t_deep_norm();
      logic [31:0] r; int lat;
      // 1.0 minus (1 - 2^-24): the aligned LSB is dropped, leaving 2^-23
      run_op(32'h40000000, 32'hBFFFFFFF, r, lat);
      check("R6 23-place renormalize", r, 32'h34800000);
      run_op(32'h40C00000, 32'hC0A00000, r, lat);
      check("R6 3 - 2.5", r, 32'h3F800000);
   endtask

   task automatic t_saturate();
      logic [31:0] r; int lat;
      run_op(32'h7FFFFFFF, 32'h7FFFFFFF, r, lat);
      check("R7 positive saturation", r, 32'h7FFFFFFF);
      run_op(32'hFFFFFFFF, 32'hFF800000, r, lat);
      check("R7 negative saturation", r, 32'hFFFFFFFF);
   endtask

   task automatic t_underflow();
      logic [31:0] r; int lat;
      run_op(32'h00C00000, 32'h80800000, r, lat);
      check("R8 underflow to zero", r, 32'h00000000);
      run_op(32'h01400000, 32'h81000000, r, lat);
      check("R8 lowest exponent kept", r, 32'h00800000);
   endtask

   task automatic t_zero_operand();
      logic [31:0] r; int lat;
      run_op(32'h00000000, 32'hC0C00000, r, lat);
      check("R9 zero plus -3", r, 32'hC0C00000);
      run_op(32'h3F912345, 32'h007FFFFF, r, lat);
      check("R9 zero with fraction bits", r, 32'h3F912345);
      run_op(32'h80000000, 32'h00000000, r, lat);
      check("R9 zero plus zero", r, 32'h00000000);
   endtask

   task automatic t_handshake();
      int lat;
      logic [31:0] held;
      @(negedge clk);
      op_a = 32'h40000000;
      op_b = 32'h40400000;
      req  = 1'b1;
      lat  = 0;
      while (!done && lat < 20) begin
         @(posedge clk);
         lat++;
         @(negedge clk);
      end
      check("R10 latency in edges", 32'(lat), 32'd4);
      held = sum_out;
      check("R1 1 + 1.5", held, 32'h40A00000);
      for (int i = 0; i < 3; i++) begin
         @(posedge clk);
         @(negedge clk);
         check("R11 done held", {31'b0, done}, 32'h1);
         check("R11 result held", sum_out, held);
      end
      req = 1'b0;
      check("R11 done before edge", {31'b0, done}, 32'h1);
      @(posedge clk);
      @(negedge clk);
      check("R11 done released", {31'b0, done}, 32'h0);
   endtask

   task automatic t_capture();
      int lat;
      @(negedge clk);
      op_a = 32'h40000000;
      op_b = 32'h40000000;
      req  = 1'b1;
      @(posedge clk);
      @(negedge clk);
      op_a = 32'hC1234567;
      op_b = 32'h7F000000;
      lat  = 1;
      while (!done && lat < 20) begin
         @(posedge clk);
         lat++;
         @(negedge clk);
      end
      check("R12 operands captured", sum_out, 32'h40800000);
      req = 1'b0;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_sweep();
      logic [31:0] x = 32'h2468ACE1;
      logic [31:0] a, b, r;
      int lat, ea, eb;
      for (int k = 0; k < 60; k++) begin
         x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
         ea = 100 + int'(x[28:23]);
         a = {x[31], 8'(ea), x[22:0]};
         x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
         eb = ea + int'(x[27:24]) - 8;
         b = {x[31], 8'(eb), x[22:0]};
         run_op(a, b, r, lat);
         check("R2 R6 sweep vs model", r, model(a, b));
         if (lat != 4) check("R10 sweep latency", 32'(lat), 32'd4);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL R10 watchdog expired: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_like_signs();
      t_unlike_signs();
      t_align();
      t_carry();
      t_deep_norm();
      t_saturate();
      t_underflow();
      t_zero_operand();
      t_handshake();
      t_capture();
      t_sweep();
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

endmodule